// File: doc/BRIEF.md
# ECC Error Monitor Register Bank

This block sits next to a SECDED decoder-corrector in a memory controller and keeps the software-visible record of what that decoder finds. On each read the decoder may pulse a single-bit or double-bit error indication. A qualifier marks double-bit errors that came from the read half of a partial-write read-modify-write. The block counts each error class in its own saturating counter. It compares each count against a programmable ceiling and records the failing address, keeping either the first or the most recent one. It collects sticky interrupt causes and raises a masked, level interrupt.

A 12-bit control word sets how the block behaves. It gates counting per error class, enables single-bit correction in the decoder, and turns on clear-on-read for the counters. It selects first or last address capture and enables deliberate corruption of codewords in the encoder, with one or two flipped bits. Two bits of the control word are write-one pulses: one wipes the counters and the captured address, and the other clears the interrupt causes. A plain register port gives access. A read presents its data one cycle after the read strobe.

Top module: `ecc_mon_regs`

## Requirements
- R1: After reset, the control word, the status (offset 1), the mask (offset 2), both counters (offsets 3 and 4) and the captured address (offset 7) read 0. Both thresholds (offsets 5 and 6) read all ones, and `irq` is 0.
- R2: The control word is at offset 0. Its bits 3, 5 and 6 are reserved and always read 0. Bits 4 and 11 are pulses and always read 0. A write of 12'hFFF reads back as 12'h787.
- R3: A single-bit event is counted, sets status bit 0 and reaches address capture only when control bit 0 is 1. A double-bit event is counted, sets status bit 1 and reaches address capture only when control bit 2 is 1.
- R4: Each counter saturates at all ones and does not wrap.
- R5: Status bit 2 (single-bit) or bit 3 (double-bit) is set when an event makes the counter strictly greater than its threshold register.
- R6: Writing control bit 4 as 1 zeroes both counters and the captured address.
- R7: With control bit 7 set, reading a counter returns its value and the counter becomes 0. With bit 7 clear, reads leave the counter unchanged.
- R8: With control bit 10 = 0, every counted error overwrites the captured address. With bit 10 = 1, only the first counted error after reset or after a clear via bit 4 is kept.
- R9: A double-bit event with `ev_rmw` high sets status bit 4 when control bit 2 is 1. A double-bit event without `ev_rmw` does not set it.
- R10: Status bits stay set until a write of control bit 11 as 1. `irq` is the OR of status ANDed with the mask (1 = enabled), and it updates on the same edge as status.
- R11: When an event arrives in the same cycle as a counter clear (bit 4 or clear-on-read) or an interrupt clear (bit 11), the event wins: the counter becomes 1 and the status bit stays set.
- R12: `fix_en`, `inj_en` and `inj_dbl` follow control bits 1, 8 and 9 respectively, from the edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after `reg_rd` |
| ev_sbe | input | 1 | Single-bit error pulse from the decoder |
| ev_dbe | input | 1 | Double-bit error pulse from the decoder |
| ev_rmw | input | 1 | Qualifies `ev_dbe` as part of a read-modify-write |
| ev_addr | input | AW | Address of the read that raised the event |
| irq | output | 1 | Level interrupt |
| fix_en | output | 1 | Single-bit correction enable to the decoder |
| inj_en | output | 1 | Codeword corruption enable to the encoder |
| inj_dbl | output | 1 | Corruption type: 0 one bit, 1 two bits |

## Verification
The bench aims at the cycles where two things collide. It puts an event in the same cycle as a counter clear or an interrupt clear. A design that let the clear win would read 0 where 1 is due, or would lose a status bit. It drives a counter past all ones; a design that wraps would read a small value. It sets a threshold of 2 and checks that status stays clear at a count of 2 and sets at 3, which catches a greater-or-equal compare. It also switches first-address capture on after a clear, so a stale held flag shows up as an old or zero address. Clear-on-read is read twice, so a counter that never clears, or one cleared without the control bit, shows up.

// File: rtl/ecc_mon_pkg.sv
package ecc_mon_pkg;
  localparam int CTRL_W = 12;
  localparam int STAT_W = 5;
  localparam int RA_W   = 3;

  typedef enum logic [RA_W-1:0] {
    RA_CTRL = 3'd0,
    RA_STAT = 3'd1,
    RA_MASK = 3'd2,
    RA_SCNT = 3'd3,
    RA_DCNT = 3'd4,
    RA_SMAX = 3'd5,
    RA_DMAX = 3'd6,
    RA_ADDR = 3'd7
  } reg_sel_e;

  // control word bit positions
  localparam int C_SBE_CNT = 0;
  localparam int C_SBE_FIX = 1;
  localparam int C_DBE_EN  = 2;
  localparam int C_CLR_ALL = 4;
  localparam int C_RD_CLR  = 7;
  localparam int C_INJ_EN  = 8;
  localparam int C_INJ_DBL = 9;
  localparam int C_FIRST   = 10;
  localparam int C_IRQ_CLR = 11;
  localparam logic [CTRL_W-1:0] CTRL_KEEP = 12'h787;

  // status bit positions
  localparam int S_SBE  = 0;
  localparam int S_DBE  = 1;
  localparam int S_SOVR = 2;
  localparam int S_DOVR = 3;
  localparam int S_RMW  = 4;
endpackage

// File: rtl/ecc_mon_counter.sv
module ecc_mon_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             over
);
  logic [CNT_W-1:0] nxt;

  always_comb begin
    nxt = count;
    if (inc) begin
      if (clr)         nxt = CNT_W'(1);
      else if (&count) nxt = count;
      else             nxt = count + CNT_W'(1);
    end else if (clr) begin
      nxt = '0;
    end
    over = inc && (nxt > limit);
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= nxt;
  end
endmodule

// File: rtl/ecc_mon_addr_cap.sv
module ecc_mon_addr_cap #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic          keep_first,
  input  logic          clr,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_q
);
  logic held;
  logic take;

  assign take = hit && (!keep_first || !held || clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      held   <= 1'b0;
    end else if (take) begin
      addr_q <= addr_in;
      held   <= 1'b1;
    end else if (clr) begin
      addr_q <= '0;
      held   <= 1'b0;
    end
  end
endmodule

// File: rtl/ecc_mon_irq.sv
module ecc_mon_irq #(
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] set,
  input  logic          clr,
  input  logic          mask_we,
  input  logic [SW-1:0] mask_wdata,
  output logic [SW-1:0] status,
  output logic [SW-1:0] mask,
  output logic          irq
);
  logic [SW-1:0] status_n;
  logic [SW-1:0] mask_n;

  always_comb begin
    status_n = (clr ? '0 : status) | set;
    mask_n   = mask_we ? mask_wdata : mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      mask   <= '0;
      irq    <= 1'b0;
    end else begin
      status <= status_n;
      mask   <= mask_n;
      irq    <= |(status_n & mask_n);
    end
  end
endmodule

// File: rtl/ecc_mon_regs.sv
module ecc_mon_regs
  import ecc_mon_pkg::*;
#(
  parameter int AW     = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ev_sbe,
  input  logic              ev_dbe,
  input  logic              ev_rmw,
  input  logic [AW-1:0]     ev_addr,
  output logic              irq,
  output logic              fix_en,
  output logic              inj_en,
  output logic              inj_dbl
);
  reg_sel_e          sel;
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  smax_q, dmax_q;
  logic [CNT_W-1:0]  sbe_cnt, dbe_cnt;
  logic              s_over, d_over;
  logic [AW-1:0]     cap_addr;
  logic [STAT_W-1:0] stat, mask, stat_set;
  logic              ctrl_we, clr_all, clr_irq;
  logic              sbe_hit, dbe_hit;
  logic              s_clr, d_clr;
  logic              unused_wbits;

  assign sel     = reg_sel_e'(reg_addr);
  assign ctrl_we = reg_wr && (sel == RA_CTRL);
  assign clr_all = ctrl_we && reg_wdata[C_CLR_ALL];
  assign clr_irq = ctrl_we && reg_wdata[C_IRQ_CLR];
  assign sbe_hit = ev_sbe && ctrl_q[C_SBE_CNT];
  assign dbe_hit = ev_dbe && ctrl_q[C_DBE_EN];
  assign s_clr   = clr_all || (reg_rd && ctrl_q[C_RD_CLR] && (sel == RA_SCNT));
  assign d_clr   = clr_all || (reg_rd && ctrl_q[C_RD_CLR] && (sel == RA_DCNT));
  assign unused_wbits = ^{reg_wdata[DATA_W-1:CTRL_W], reg_wdata[6:5], reg_wdata[3]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      smax_q <= '1;
      dmax_q <= '1;
    end else if (reg_wr) begin
      case (sel)
        RA_CTRL: ctrl_q <= reg_wdata[CTRL_W-1:0] & CTRL_KEEP;
        RA_SMAX: smax_q <= reg_wdata[CNT_W-1:0];
        RA_DMAX: dmax_q <= reg_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  ecc_mon_counter #(.CNT_W(CNT_W)) u_scnt (
    .clk(clk), .rst(rst), .inc(sbe_hit), .clr(s_clr),
    .limit(smax_q), .count(sbe_cnt), .over(s_over)
  );

  ecc_mon_counter #(.CNT_W(CNT_W)) u_dcnt (
    .clk(clk), .rst(rst), .inc(dbe_hit), .clr(d_clr),
    .limit(dmax_q), .count(dbe_cnt), .over(d_over)
  );

  ecc_mon_addr_cap #(.AW(AW)) u_cap (
    .clk(clk), .rst(rst), .hit(sbe_hit || dbe_hit),
    .keep_first(ctrl_q[C_FIRST]), .clr(clr_all),
    .addr_in(ev_addr), .addr_q(cap_addr)
  );

  always_comb begin
    stat_set         = '0;
    stat_set[S_SBE]  = sbe_hit;
    stat_set[S_DBE]  = dbe_hit;
    stat_set[S_SOVR] = s_over;
    stat_set[S_DOVR] = d_over;
    stat_set[S_RMW]  = dbe_hit && ev_rmw;
  end

  ecc_mon_irq #(.SW(STAT_W)) u_irq (
    .clk(clk), .rst(rst), .set(stat_set), .clr(clr_irq),
    .mask_we(reg_wr && (sel == RA_MASK)),
    .mask_wdata(reg_wdata[STAT_W-1:0]),
    .status(stat), .mask(mask), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (sel)
        RA_CTRL: reg_rdata <= DATA_W'(ctrl_q);
        RA_STAT: reg_rdata <= DATA_W'(stat);
        RA_MASK: reg_rdata <= DATA_W'(mask);
        RA_SCNT: reg_rdata <= DATA_W'(sbe_cnt);
        RA_DCNT: reg_rdata <= DATA_W'(dbe_cnt);
        RA_SMAX: reg_rdata <= DATA_W'(smax_q);
        RA_DMAX: reg_rdata <= DATA_W'(dmax_q);
        RA_ADDR: reg_rdata <= DATA_W'(cap_addr);
        default: reg_rdata <= '0;
      endcase
    end
  end

  assign fix_en  = ctrl_q[C_SBE_FIX];
  assign inj_en  = ctrl_q[C_INJ_EN];
  assign inj_dbl = ctrl_q[C_INJ_DBL];
endmodule

// File: rtl/ecc_mon_regs_sva.sv
module ecc_mon_regs_sva
  import ecc_mon_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [RA_W-1:0]   reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              ev_sbe,
  input logic [CTRL_W-1:0] ctrl,
  input logic [CNT_W-1:0]  scnt,
  input logic [STAT_W-1:0] status,
  input logic [STAT_W-1:0] mask,
  input logic              irq,
  input logic              inj_en,
  input logic              inj_dbl
);
  logic past_rst = 1'b0;
  logic cw, clr_wr, irq_wr, scnt_rd;

  always_ff @(posedge clk) past_rst <= rst;

  assign cw      = reg_wr && (reg_addr == RA_CTRL);
  assign clr_wr  = cw && reg_wdata[C_CLR_ALL];
  assign irq_wr  = cw && reg_wdata[C_IRQ_CLR];
  assign scnt_rd = reg_rd && (reg_addr == RA_SCNT);

  assert_reset_R1: assert property (@(posedge clk)
    past_rst |-> (status == '0 && !irq && scnt == '0));

  assert_ctrl_rsvd_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == RA_CTRL) |=>
      (reg_rdata[3] == 1'b0 && reg_rdata[4] == 1'b0 && reg_rdata[5] == 1'b0 &&
       reg_rdata[6] == 1'b0 && reg_rdata[11] == 1'b0));

  assert_sbe_gate_R3: assert property (@(posedge clk) disable iff (rst)
    (!ctrl[C_SBE_CNT] && !clr_wr && !scnt_rd) |=> $stable(scnt));

  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (scnt == '1 && !clr_wr && !scnt_rd) |=> scnt == '1);

  assert_clear_on_read_R7: assert property (@(posedge clk) disable iff (rst)
    (scnt_rd && ctrl[C_RD_CLR] && !(ev_sbe && ctrl[C_SBE_CNT])) |=> scnt == '0);

  assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    !irq_wr |=> ((status & $past(status)) == $past(status)));

  assert_irq_level_R10: assert property (@(posedge clk) disable iff (rst)
    irq == |(status & mask));

  assert_event_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && ev_sbe && ctrl[C_SBE_CNT]) |=> scnt == CNT_W'(1));

  assert_inject_R12: assert property (@(posedge clk) disable iff (rst)
    cw |=> (inj_en == $past(reg_wdata[C_INJ_EN]) && inj_dbl == $past(reg_wdata[C_INJ_DBL])));
endmodule

bind ecc_mon_regs ecc_mon_regs_sva #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_sva (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_sbe(ev_sbe), .ctrl(ctrl_q),
  .scnt(sbe_cnt), .status(stat), .mask(mask), .irq(irq),
  .inj_en(inj_en), .inj_dbl(inj_dbl)
);

// File: tb/ecc_mon_regs_test.sv
`timescale 1ns/1ps
module ecc_mon_regs_test;
  localparam int AW = 16;
  localparam int CNT_W = 4;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic ev_sbe = 1'b0, ev_dbe = 1'b0, ev_rmw = 1'b0;
  logic [AW-1:0] ev_addr = '0;
  logic irq, fix_en, inj_en, inj_dbl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ecc_mon_regs #(.AW(AW), .CNT_W(CNT_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_sbe(ev_sbe), .ev_dbe(ev_dbe),
    .ev_rmw(ev_rmw), .ev_addr(ev_addr), .irq(irq), .fix_en(fix_en),
    .inj_en(inj_en), .inj_dbl(inj_dbl)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic evt(input logic s, input logic dd, input logic m, input logic [AW-1:0] a);
    @(negedge clk);
    ev_sbe = s; ev_dbe = dd; ev_rmw = m; ev_addr = a;
    @(negedge clk);
    ev_sbe = 1'b0; ev_dbe = 1'b0; ev_rmw = 1'b0;
  endtask

  task automatic wr_with_sbe(input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = d; ev_sbe = 1'b1; ev_addr = 16'h0abc;
    @(negedge clk);
    reg_wr = 1'b0; ev_sbe = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int i = 0; i < 8; i++) begin
      rd(i[2:0], d);
      chk($sformatf("R1 reg %0d", i), d, (i == 5 || i == 6) ? 32'hf : 32'h0);
    end
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    wr(3'd0, 32'hfff);
    rd(3'd0, d);
    chk("R2 ctrl readback", d, 32'h787);
    chk("R12 outputs all set", {29'b0, fix_en, inj_en, inj_dbl}, 32'h7);
    wr(3'd0, 32'h100);
    chk("R12 single-bit inject", {29'b0, fix_en, inj_en, inj_dbl}, 32'h2);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_gate();
    logic [31:0] d;
    evt(1'b1, 1'b0, 1'b0, 16'h10);
    rd(3'd3, d); chk("R3 sbe ignored when disabled", d, 32'h0);
    rd(3'd1, d); chk("R3 status untouched when disabled", d, 32'h0);
    wr(3'd0, 32'h1);
    repeat (3) evt(1'b1, 1'b0, 1'b0, 16'h10);
    rd(3'd3, d); chk("R3 sbe count", d, 32'h3);
    evt(1'b0, 1'b1, 1'b0, 16'h20);
    rd(3'd4, d); chk("R3 dbe ignored when disabled", d, 32'h0);
    wr(3'd0, 32'h5);
    evt(1'b0, 1'b1, 1'b0, 16'h20);
    rd(3'd4, d); chk("R3 dbe count", d, 32'h1);
    rd(3'd1, d); chk("R3 status bits 0 and 1", d, 32'h3);
    wr(3'd0, 32'h815);
    rd(3'd3, d); chk("R6 sbe counter cleared", d, 32'h0);
    rd(3'd4, d); chk("R6 dbe counter cleared", d, 32'h0);
    rd(3'd1, d); chk("R10 status cleared by bit 11", d, 32'h0);
  endtask

  task automatic t_thresh();
    logic [31:0] d;
    wr(3'd5, 32'h2);
    wr(3'd2, 32'h4);
    repeat (2) evt(1'b1, 1'b0, 1'b0, 16'h1);
    rd(3'd1, d); chk("R5 count equal to max, no flag", d, 32'h1);
    chk("R10 irq masked low", {31'b0, irq}, 32'h0);
    evt(1'b1, 1'b0, 1'b0, 16'h1);
    chk("R10 irq rises with status", {31'b0, irq}, 32'h1);
    rd(3'd1, d); chk("R5 count above max", d, 32'h5);
    wr(3'd0, 32'h805);
    chk("R10 irq cleared", {31'b0, irq}, 32'h0);
    rd(3'd1, d); chk("R10 status cleared", d, 32'h0);
    wr(3'd5, 32'hf);
    wr(3'd0, 32'h815);
  endtask

  task automatic t_sat();
    logic [31:0] d;
    repeat (20) evt(1'b1, 1'b0, 1'b0, 16'h2);
    rd(3'd3, d); chk("R4 saturates", d, 32'hf);
    wr(3'd0, 32'h815);
  endtask

  task automatic t_cor();
    logic [31:0] d;
    wr(3'd0, 32'h85);
    repeat (3) evt(1'b1, 1'b0, 1'b0, 16'h3);
    rd(3'd3, d); chk("R7 read returns value", d, 32'h3);
    rd(3'd3, d); chk("R7 counter zero after read", d, 32'h0);
    wr(3'd0, 32'h5);
    repeat (2) evt(1'b1, 1'b0, 1'b0, 16'h3);
    rd(3'd3, d); chk("R7 plain read", d, 32'h2);
    rd(3'd3, d); chk("R7 plain read keeps value", d, 32'h2);
    wr(3'd0, 32'h815);
  endtask

  task automatic t_addr();
    logic [31:0] d;
    wr(3'd0, 32'h5);
    evt(1'b1, 1'b0, 1'b0, 16'h111);
    evt(1'b0, 1'b1, 1'b0, 16'h222);
    rd(3'd7, d); chk("R8 last address", d, 32'h222);
    wr(3'd0, 32'h415);
    rd(3'd7, d); chk("R6 address cleared", d, 32'h0);
    evt(1'b1, 1'b0, 1'b0, 16'h333);
    evt(1'b0, 1'b1, 1'b0, 16'h444);
    rd(3'd7, d); chk("R8 first address kept", d, 32'h333);
    wr(3'd0, 32'h415);
    evt(1'b1, 1'b0, 1'b0, 16'h555);
    rd(3'd7, d); chk("R8 first address after clear", d, 32'h555);
    wr(3'd0, 32'h815);
  endtask

  task automatic t_rmw();
    logic [31:0] d;
    evt(1'b0, 1'b1, 1'b1, 16'h6);
    rd(3'd1, d); chk("R9 rmw double-bit", d, 32'h12);
    wr(3'd0, 32'h805);
    evt(1'b0, 1'b1, 1'b0, 16'h6);
    rd(3'd1, d); chk("R9 no rmw flag", d, 32'h2);
    wr(3'd0, 32'h801);
    evt(1'b0, 1'b1, 1'b1, 16'h6);
    rd(3'd1, d); chk("R9 rmw ignored when dbe disabled", d, 32'h0);
    wr(3'd0, 32'h815);
  endtask

  task automatic t_win();
    logic [31:0] d;
    repeat (2) evt(1'b1, 1'b0, 1'b0, 16'h7);
    wr_with_sbe(32'h015);
    rd(3'd3, d); chk("R11 event beats counter clear", d, 32'h1);
    wr_with_sbe(32'h805);
    rd(3'd1, d); chk("R11 event beats interrupt clear", d, 32'h1);
    wr(3'd0, 32'h85);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 3'd3; ev_sbe = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0; ev_sbe = 1'b0;
    chk("R11 read returns old value", reg_rdata, 32'h2);
    rd(3'd3, d); chk("R11 event beats clear-on-read", d, 32'h1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ctrl();
    t_gate();
    t_thresh();
    t_sat();
    t_cor();
    t_addr();
    t_rmw();
    t_win();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule